// File: doc/BRIEF.md
# Instruction Cache Line-Fill Controller

This block sits between a 32-bit processor fetch port and a 16-bit external memory port. Every core request, instruction or data, passes through it. Instruction fetches are looked up in a small direct-mapped cache. On a hit, the word comes from on-chip storage and the shared external bus is never requested.

On a miss to an unlocked line, the controller does three things in order. It asks for the bus and waits for the grant. It reads the whole line as a burst of halfwords starting at the line-aligned address. It then marks the line valid and returns the requested word.

A line whose lock bit is set is never replaced. A miss that maps onto a locked line fetches only the addressed word, as two halfwords, and passes it through. Data reads, and all fetches while the cache is disabled, take the same single-word uncached path and leave the cache untouched.

Top module: `icache_fill_ctrl`

## Requirements
- R1: After reset, `core_ready` is 1, and `rsp_valid`, `bus_req` and `mem_rd` are all 0. Every line is invalid, so the first fetch of any address misses.
- R2: A hit is an instruction fetch, with the cache enabled, to a valid line whose tag matches. It raises `rsp_valid` with the cached word on the second clock edge after the request is accepted. `bus_req` stays low for the whole access.
- R3: An instruction miss to an unlocked line, with the cache enabled, issues exactly 2×LINE_WORDS halfword reads. They go to consecutive even addresses starting at the line-aligned address. Afterwards, a fetch of any word of that line hits.
- R4: Two halfwords form one 32-bit word. The halfword at the lower address goes in bits [15:0] and the one at the higher address in bits [31:16].
- R5: An instruction miss onto a locked line issues exactly two halfword reads, at the word-aligned address and that address plus 2, and returns that word. The line's previous contents stay valid and still hit.
- R6: A data read (`core_instr`=0) always issues exactly two halfword reads at the word-aligned address, even when the address is cached. It does not change the cache.
- R7: While `cache_en` is 0, an instruction fetch behaves as an uncached single-word read, even to a valid line. The cache contents are kept for later use with the cache enabled.
- R8: `bus_req` is raised only for a miss or a data read. `mem_rd` is asserted only while `bus_req` is high, and it rises only after a clock edge at which `bus_gnt` was high. `bus_req` drops at the edge that takes the final halfword.
- R9: A fill returns its word on the second clock edge after the final halfword is accepted, because the tag update comes first. A single-word read returns on the first edge after its final halfword.
- R10: While `mem_rd` is high and `mem_ack` is low, `mem_addr` holds its value and `mem_rd` stays high. Every `mem_addr` is even.
- R11: Only one request is outstanding at a time. `core_ready` is low from acceptance until the cycle in which `rsp_valid` is high, and in that cycle it is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cache_en | input | 1 | Cache enable; when 0, every fetch is uncached |
| line_lock | input | 2**IDX_W | Lock bit per cache line |
| core_req | input | 1 | Request strobe; taken when `core_ready` is 1 |
| core_instr | input | 1 | 1 = instruction fetch, 0 = data read |
| core_addr | input | ADDR_W | Byte address (word aligned) |
| core_ready | output | 1 | Idle and able to take a request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 32 | Returned word |
| bus_req | output | 1 | Request for the shared external bus |
| bus_gnt | input | 1 | Bus grant |
| mem_rd | output | 1 | Halfword read request, held until acknowledged |
| mem_addr | output | ADDR_W | Byte address of the halfword |
| mem_rdata | input | 16 | Halfword returned with `mem_ack` |
| mem_ack | input | 1 | Read completes in this cycle |

## Verification
The bench builds the block with ADDR_W=16, IDX_W=2 and LINE_WORDS=4. That gives four lines with a 10-bit tag, so a small address pool quickly produces conflicting tags, evictions, and locked lines that hold older data. Grant and acknowledge delays vary from cycle to cycle. This exercises address hold during stalls and lets the final halfword land at varying times, so the return latency after that halfword is checked under many arrival patterns.

// File: rtl/icf_pkg.sv
package icf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_REQ,
    ST_XFER,
    ST_COMMIT
  } icf_state_e;
endpackage

// File: rtl/icf_tag_store.sv
module icf_tag_store #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_valid,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0] tag_mem [LINES];
  logic [LINES-1:0] vld;

  // tag array: no reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
    rd_tag <= tag_mem[rd_idx];
  end

  // valid bits live in flops so reset clears them
  always_ff @(posedge clk) begin
    if (rst) begin
      vld      <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_en) vld[wr_idx] <= 1'b1;
      rd_valid <= vld[rd_idx];
    end
  end
endmodule

// File: rtl/icf_data_store.sv
module icf_data_store #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/icf_hw_pack.sv
module icf_hw_pack (
  input  logic        clk,
  input  logic        take,
  input  logic        upper,
  input  logic [15:0] hw_in,
  output logic [31:0] word
);
  logic [15:0] lo_q;

  always_ff @(posedge clk) begin
    if (take && !upper) lo_q <= hw_in;
  end

  assign word = {hw_in, lo_q};
endmodule

// File: rtl/icache_fill_ctrl.sv
module icache_fill_ctrl #(
  parameter int ADDR_W     = 20,
  parameter int IDX_W      = 4,
  parameter int LINE_WORDS = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cache_en,
  input  logic [(1<<IDX_W)-1:0] line_lock,
  input  logic                  core_req,
  input  logic                  core_instr,
  input  logic [ADDR_W-1:0]     core_addr,
  output logic                  core_ready,
  output logic                  rsp_valid,
  output logic [31:0]           rsp_data,
  output logic                  bus_req,
  input  logic                  bus_gnt,
  output logic                  mem_rd,
  output logic [ADDR_W-1:0]     mem_addr,
  input  logic [15:0]           mem_rdata,
  input  logic                  mem_ack
);
  import icf_pkg::*;

  localparam int OFF_W   = $clog2(LINE_WORDS);
  localparam int CNT_W   = OFF_W + 1;
  localparam int HW_LINE = 2 * LINE_WORDS;
  localparam int TAG_W   = ADDR_W - IDX_W - OFF_W - 2;
  localparam int DA_W    = IDX_W + OFF_W;
  localparam logic [CNT_W-1:0] LAST_FILL   = CNT_W'(HW_LINE - 1);
  localparam logic [CNT_W-1:0] LAST_SINGLE = CNT_W'(1);

  icf_state_e state;

  logic [ADDR_W-1:0] addr_q;
  logic              instr_q;
  logic              fill_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [31:0]       result_q;

  logic [IDX_W-1:0]  idx_q;
  logic [TAG_W-1:0]  tag_a;
  logic [OFF_W-1:0]  woff_q;
  logic [TAG_W-1:0]  rd_tag;
  logic              rd_valid;
  logic [31:0]       rd_word;
  logic [31:0]       packed_word;
  logic              hit;
  logic              do_fill;
  logic              hw_last;
  logic              took_hw;
  logic              dwr_en;
  logic              twr_en;
  logic [ADDR_W-1:0] line_base;
  logic [ADDR_W-1:0] word_base;

  // address fields of the captured request
  assign idx_q  = addr_q[2+OFF_W +: IDX_W];
  assign tag_a  = addr_q[ADDR_W-1 -: TAG_W];
  assign woff_q = addr_q[2 +: OFF_W];

  assign line_base = {addr_q[ADDR_W-1:2+OFF_W], {(OFF_W+2){1'b0}}};
  assign word_base = {addr_q[ADDR_W-1:2], 2'b00};

  // lookup and miss decisions, all taken in ST_LOOK
  assign hit     = instr_q && cache_en && rd_valid && (rd_tag == tag_a);
  assign do_fill = instr_q && cache_en && !line_lock[idx_q];

  // burst progress
  assign took_hw = (state == ST_XFER) && mem_ack;
  assign hw_last = cnt_q == (fill_q ? LAST_FILL : LAST_SINGLE);
  assign dwr_en  = took_hw && cnt_q[0] && fill_q;
  assign twr_en  = (state == ST_COMMIT);

  assign core_ready = (state == ST_IDLE);

  icf_tag_store #(
    .IDX_W(IDX_W),
    .TAG_W(TAG_W)
  ) u_tags (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (core_addr[2+OFF_W +: IDX_W]),
    .rd_tag  (rd_tag),
    .rd_valid(rd_valid),
    .wr_en   (twr_en),
    .wr_idx  (idx_q),
    .wr_tag  (tag_a)
  );

  icf_data_store #(
    .AW(DA_W)
  ) u_data (
    .clk    (clk),
    .wr_en  (dwr_en),
    .wr_addr({idx_q, cnt_q[CNT_W-1:1]}),
    .wr_data(packed_word),
    .rd_addr(core_addr[2 +: DA_W]),
    .rd_data(rd_word)
  );

  icf_hw_pack u_pack (
    .clk  (clk),
    .take (took_hw),
    .upper(cnt_q[0]),
    .hw_in(mem_rdata),
    .word (packed_word)
  );

  // keep the requested word while the remainder of the line streams in
  always_ff @(posedge clk) begin
    if (took_hw && cnt_q[0] && (!fill_q || cnt_q[CNT_W-1:1] == woff_q))
      result_q <= packed_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      addr_q    <= '0;
      instr_q   <= 1'b0;
      fill_q    <= 1'b0;
      cnt_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      bus_req   <= 1'b0;
      mem_rd    <= 1'b0;
      mem_addr  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (core_req) begin
            addr_q  <= core_addr;
            instr_q <= core_instr;
            state   <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (hit) begin
            rsp_valid <= 1'b1;
            rsp_data  <= rd_word;
            state     <= ST_IDLE;
          end else begin
            fill_q   <= do_fill;
            cnt_q    <= '0;
            bus_req  <= 1'b1;
            mem_addr <= do_fill ? line_base : word_base;
            state    <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (bus_gnt) begin
            mem_rd <= 1'b1;
            state  <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (mem_ack) begin
            cnt_q    <= cnt_q + CNT_W'(1);
            mem_addr <= mem_addr + ADDR_W'(2);
            if (hw_last) begin
              mem_rd  <= 1'b0;
              bus_req <= 1'b0;
              if (fill_q) begin
                state <= ST_COMMIT;
              end else begin
                rsp_valid <= 1'b1;
                rsp_data  <= packed_word;
                state     <= ST_IDLE;
              end
            end
          end
        end
        ST_COMMIT: begin
          rsp_valid <= 1'b1;
          rsp_data  <= result_q;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/icf_fill_checker.sv
module icf_fill_checker #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              core_ready,
  input logic              rsp_valid,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack
);
  AST_RD_UNDER_REQ: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> bus_req);                                            // R8

  AST_RD_AFTER_GNT: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_rd) |-> $past(bus_gnt));                              // R8

  AST_IDLE_NO_BUS: assert property (@(posedge clk) disable iff (rst)
    core_ready |-> !bus_req);                                       // R8

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && !mem_ack) |=> (mem_rd && $stable(mem_addr)));        // R10

  AST_HW_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> !mem_addr[0]);                                       // R10

  AST_RSP_FREES_CORE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> core_ready);                                      // R11

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);                                      // R11
endmodule

bind icache_fill_ctrl icf_fill_checker #(
  .ADDR_W(ADDR_W)
) u_fill_chk (
  .clk       (clk),
  .rst       (rst),
  .core_ready(core_ready),
  .rsp_valid (rsp_valid),
  .bus_req   (bus_req),
  .bus_gnt   (bus_gnt),
  .mem_rd    (mem_rd),
  .mem_addr  (mem_addr),
  .mem_ack   (mem_ack)
);

// File: tb/icache_fill_ctrl_test.sv
`timescale 1ns/1ps
module icache_fill_ctrl_test;
  localparam int AW = 16;
  localparam int IW = 2;
  localparam int LW = 4;
  localparam int NL = 1 << IW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cache_en = 1'b1;
  logic [NL-1:0] line_lock = '0;
  logic          core_req = 1'b0;
  logic          core_instr = 1'b0;
  logic [AW-1:0] core_addr = '0;
  logic          core_ready, rsp_valid, bus_req, mem_rd;
  logic [31:0]   rsp_data;
  logic [AW-1:0] mem_addr;
  logic          bus_gnt = 1'b0;
  logic          mem_ack = 1'b0;
  logic [15:0]   mem_rdata = '0;

  int total = 0;
  int bad = 0;
  int gwait = 0;

  // reference cache state
  logic       m_valid [NL];
  logic [9:0] m_tag   [NL];

  always #2.5 clk = ~clk;

  icache_fill_ctrl #(.ADDR_W(AW), .IDX_W(IW), .LINE_WORDS(LW)) uut (
    .clk(clk), .rst(rst), .cache_en(cache_en), .line_lock(line_lock),
    .core_req(core_req), .core_instr(core_instr), .core_addr(core_addr),
    .core_ready(core_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_ack(mem_ack));

  function automatic logic [15:0] hw(input logic [15:0] a);
    return (a * 16'd40503) ^ 16'h6B1D;
  endfunction

  function automatic logic [31:0] word_at(input logic [15:0] a);
    return {hw(a + 16'd2), hw(a)};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // external memory and arbiter: driven just after each edge, sampled at negedge
  always @(posedge clk) begin
    #1;
    if (!bus_req) begin
      bus_gnt <= 1'b0;
      gwait   <= $urandom_range(0, 3);
    end else if (gwait == 0) bus_gnt <= 1'b1;
    else gwait <= gwait - 1;
    mem_ack   <= mem_rd && ($urandom_range(0, 3) != 0);
    mem_rdata <= hw(mem_addr);
  end

  task automatic do_access(input logic [15:0] a, input logic ins);
    int idx = int'(a[5:4]);
    logic [9:0] tg = a[15:6];
    bit hit, fill, gnt_seen, bus_on_hit, ready_bad;
    logic [15:0] q[$];
    logic [15:0] base;
    int cyc = 0, last_ack = 0;
    string tag;
    hit  = ins && cache_en && m_valid[idx] && (m_tag[idx] == tg);
    fill = ins && cache_en && !hit && !line_lock[idx];
    if (hit) tag = "R2";
    else if (fill) tag = "R3";
    else if (!ins) tag = "R6";
    else if (!cache_en) tag = "R7";
    else tag = "R5";
    if (!hit) begin
      base = fill ? {a[15:4], 4'h0} : {a[15:2], 2'b00};
      for (int i = 0; i < (fill ? 2 * LW : 2); i++) q.push_back(base + 16'(2 * i));
    end
    while (!core_ready) @(negedge clk);
    @(posedge clk); #1;
    core_req = 1'b1; core_addr = a; core_instr = ins;
    @(posedge clk); #1;
    core_req = 1'b0;
    gnt_seen = 0; bus_on_hit = 0; ready_bad = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (hit && bus_req) bus_on_hit = 1;
      if (mem_rd && !gnt_seen) chk(0, "R8 read before grant", mem_rd, 0);
      if (bus_gnt && bus_req) gnt_seen = 1;
      if (mem_rd && mem_ack) begin
        if (q.size() == 0) chk(0, {tag, " extra halfword read"}, mem_addr, 0);
        else begin
          logic [15:0] e = q.pop_front();
          chk(mem_addr == e, {tag, " halfword address"}, mem_addr, e);
        end
        last_ack = cyc;
      end
      if (rsp_valid) break;
      if (core_ready) ready_bad = 1;
      if (cyc > 400) begin
        chk(0, {tag, " no response"}, cyc, 0);
        break;
      end
    end
    chk(!ready_bad, "R11 ready during access", ready_bad, 0);
    chk(core_ready, "R11 ready with response", core_ready, 1);
    chk(rsp_data == word_at({a[15:2], 2'b00}), {tag, " R4 data"}, rsp_data, word_at({a[15:2], 2'b00}));
    chk(q.size() == 0, {tag, " reads missing"}, q.size(), 0);
    chk(!bus_req, "R8 bus released", bus_req, 0);
    if (hit) begin
      chk(!bus_on_hit, "R2 bus used on hit", bus_on_hit, 0);
      chk(cyc == 2, "R2 hit latency", cyc, 2);
    end else begin
      chk(cyc - last_ack == (fill ? 2 : 1), "R9 return latency", cyc - last_ack, fill ? 2 : 1);
    end
    if (fill) begin m_valid[idx] = 1'b1; m_tag[idx] = tg; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NL; i++) begin m_valid[i] = 1'b0; m_tag[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(core_ready == 1'b1, "R1 ready", core_ready, 1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
    chk(bus_req == 1'b0, "R1 bus_req", bus_req, 0);
    chk(mem_rd == 1'b0, "R1 mem_rd", mem_rd, 0);

    // R3/R1: cold miss fills line 1 (tag 1)
    do_access(16'h0054, 1'b1);
    // R2: other words of the filled line hit
    do_access(16'h0050, 1'b1);
    do_access(16'h005C, 1'b1);
    // R6: data read to cached address still goes to memory
    do_access(16'h0058, 1'b0);
    do_access(16'h0058, 1'b1);
    // R5: lock line 1, conflicting tag reads one word only
    line_lock[1] = 1'b1;
    do_access(16'h0098, 1'b1);
    do_access(16'h0054, 1'b1);
    do_access(16'h0098, 1'b1);
    // R7: disabled cache ignores valid line, keeps it
    cache_en = 1'b0;
    do_access(16'h0054, 1'b1);
    cache_en = 1'b1;
    do_access(16'h0054, 1'b1);
    // R3: fill for word 2 of a fresh line, then unlock and evict
    do_access(16'h0128, 1'b1);
    do_access(16'h0120, 1'b1);
    line_lock[1] = 1'b0;
    do_access(16'h0098, 1'b1);
    do_access(16'h0054, 1'b1);

    for (int n = 0; n < 300; n++) begin
      logic [15:0] a;
      a = {8'h00, 2'($urandom_range(0, 2)), 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), 2'b00};
      if ($urandom_range(0, 15) == 0) line_lock = NL'($urandom_range(0, NL - 1));
      cache_en = ($urandom_range(0, 9) != 0);
      do_access(a, $urandom_range(0, 4) != 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule